// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a small direct-memory-access controller. Software programs four registers through a narrow write port: a control word, a transfer count, a peripheral-side address and a memory-side address. Once enabled, the channel moves data items one at a time. Each item is a read on a simple bus-master port followed by a write on the same port. The direction bit decides which side is the source. Each side has its own data size and its own optional address increment.

An item starts either when a peripheral raises its request line, or back to back when memory-to-memory operation is selected. The remaining count drops by one for every item that completes. When the count runs out, normal operation leaves the count at zero and the channel goes quiet. Circular operation restores both the count and the two address pointers and keeps going. Three single-cycle event outputs report completion, the half-way point and bus errors, each gated by its own enable bit. An error response also switches the channel off.

Top module: `dma_chan_engine`

## Requirements
- R1: After synchronous reset, the control word, remaining count, both address pointers and all bus and event outputs are zero.
- R2: A write with `cfg_sel` 0 loads the control word. Its bit layout is: bit 0 enable, bit 1 completion-event enable, bit 2 half-event enable, bit 3 error-event enable, bit 4 direction (0 = peripheral to memory, 1 = memory to peripheral), bit 5 circular, bit 6 peripheral increment, bit 7 memory increment, bits 9:8 peripheral size, bits 11:10 memory size, bits 13:12 priority, bit 14 memory-to-memory. Writes with `cfg_sel` 2 and 3 load the peripheral and memory address pointers.
- R3: A write with `cfg_sel` 1 sets both the programmed count and the remaining count, but only while the enable bit is clear. The same write made while the channel is enabled leaves the count unchanged.
- R4: Each item is one read command (`bus_write` = 0) to the source pointer at the source size, then one write command (`bus_write` = 1) to the destination pointer at the destination size.
- R5: After an item completes, each side's pointer advances by 1, 2 or 4 for size codes 0, 1 and 2 (code 3 behaves as 4), but only if that side's increment bit is set. Otherwise the pointer stays fixed.
- R6: Each completed item lowers the remaining count by one. When the last item of a pass completes, completion is signalled. In normal operation the count then stays at zero and no further read is issued.
- R7: In circular operation, completing the last item restores the remaining count to the programmed value and both pointers to their programmed addresses, and transfers continue.
- R8: The half event fires once per pass, on the first item after which twice the remaining count is no more than the programmed count.
- R9: An error response to either command raises the error event, clears the enable bit, and leaves the count and pointers as they were before that item.
- R10: With memory-to-memory clear, an item starts only while `per_req` is high and the channel is enabled with a nonzero count. With it set, items follow each other without a request.
- R11: Each event output pulses for one cycle, and only when its enable bit in the control word is set.
- R12: The written data is the read data masked to the smaller of the two sizes (8, 16 or 32 bits), with the upper bits zero.
- R13: A command holds its address, size and direction while `bus_ready` is low. No new command is issued while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 count, 2 peripheral address, 3 memory address |
| cfg_wdata | input | AW | Register write data |
| per_req | input | 1 | Peripheral transfer request |
| bus_valid | output | 1 | Command valid |
| bus_write | output | 1 | Command is a write |
| bus_addr | output | AW | Command byte address |
| bus_size | output | 2 | Command size code |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Command accepted when high with `bus_valid` |
| bus_rsp_valid | input | 1 | Response for the outstanding command |
| bus_rsp_rdata | input | 32 | Read response data |
| bus_rsp_err | input | 1 | Response carries an error |
| evt_done | output | 1 | Completion event pulse |
| evt_half | output | 1 | Half-way event pulse |
| evt_err | output | 1 | Bus error event pulse |
| ctrl_out | output | 16 | Current control word (bit 15 zero) |
| remain_cnt | output | CW | Remaining item count |
| per_addr | output | AW | Current peripheral-side pointer |
| mem_addr | output | AW | Current memory-side pointer |

## Verification
The bound checker watches every cycle for these properties: commands stay stable under back-pressure, only one command is outstanding, a read starts only when the channel is enabled with a nonzero count, and the count moves by at most a decrement or a reload while the channel is enabled. It also checks that an error response disables the channel and fires the error event, and that completion in normal operation leaves the count at zero. Several behaviours can only be shown by the bench's scenarios, because they depend on the exact addresses, data and counts across a whole pass. These are the address sequence and masked data for each size pair, the circular reload of pointers, the single half event per pass, request gating, and the suppression of events whose enable bit is clear.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int CTRL_W = 15;
    localparam int DATA_W = 32;

    // Control word; bit positions matter because software decodes them.
    typedef struct packed {
        logic       m2m;      // 14
        logic [1:0] prio;     // 13:12
        logic [1:0] msize;    // 11:10
        logic [1:0] psize;    // 9:8
        logic       minc;     // 7
        logic       pinc;     // 6
        logic       circ;     // 5
        logic       dir;      // 4
        logic       err_ie;   // 3
        logic       half_ie;  // 2
        logic       done_ie;  // 1
        logic       en;       // 0
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_PADDR = 2'd2,
        SEL_MADDR = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT
    } seq_state_e;

    function automatic logic [2:0] size_step(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return DATA_W'(32'h0000_00FF);
            2'd1:    return DATA_W'(32'h0000_FFFF);
            default: return {DATA_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/dma_ch_ctrl_reg.sv
module dma_ch_ctrl_reg
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] wdata,
    input  logic          hw_disable,
    output ctrl_t         ctrl
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = wr ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
        if (hw_disable) begin
            ctrl_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/dma_ch_counter.sv
module dma_ch_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          en,
    input  logic          circ,
    input  logic          beat_done,
    output logic [CW-1:0] remain,
    output logic          nonzero,
    output logic          wrap,
    output logic          done_pulse,
    output logic          half_pulse
);
    logic [CW-1:0] prog_q;
    logic [CW-1:0] remain_q;
    logic          half_seen_q;
    logic          done_q;
    logic          half_q;

    logic [CW-1:0] dec;
    logic          is_last;
    logic          half_hit;

    assign dec      = remain_q - CW'(1);
    assign is_last  = (remain_q == CW'(1));
    assign half_hit = (({1'b0, dec} << 1) <= {1'b0, prog_q});
    assign wrap     = beat_done && is_last && circ;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q      <= '0;
            remain_q    <= '0;
            half_seen_q <= 1'b0;
            done_q      <= 1'b0;
            half_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            half_q <= 1'b0;
            if (wr && !en) begin
                prog_q      <= wdata;
                remain_q    <= wdata;
                half_seen_q <= 1'b0;
            end else if (beat_done) begin
                remain_q <= wrap ? prog_q : dec;
                done_q   <= is_last;
                if (!half_seen_q && half_hit) begin
                    half_q      <= 1'b1;
                    half_seen_q <= 1'b1;
                end
                if (wrap) begin
                    half_seen_q <= 1'b0;
                end
            end
        end
    end

    assign remain     = remain_q;
    assign nonzero    = (remain_q != '0);
    assign done_pulse = done_q;
    assign half_pulse = half_q;
endmodule

// File: rtl/dma_ch_addr_ptr.sv
module dma_ch_addr_ptr
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] wdata,
    input  logic          step_en,
    input  logic [1:0]    size,
    input  logic          reload,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (wr) begin
            base_q <= wdata;
            cur_q  <= wdata;
        end else if (reload) begin
            cur_q <= base_q;
        end else if (step_en) begin
            cur_q <= cur_q + AW'(size_step(size));
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     src_addr,
    input  logic [AW-1:0]     dst_addr,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    input  logic              bus_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    input  logic              rsp_err,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              beat_done,
    output logic              err_hit
);
    seq_state_e        st_q;
    seq_state_e        st_d;
    logic [DATA_W-1:0] data_q;
    logic              waiting;

    assign waiting   = (st_q == ST_RD_WAIT) || (st_q == ST_WR_WAIT);
    assign err_hit   = waiting && rsp_valid && rsp_err;
    assign beat_done = (st_q == ST_WR_WAIT) && rsp_valid && !rsp_err;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (start) st_d = ST_RD_REQ;
            ST_RD_REQ:  if (bus_ready) st_d = ST_RD_WAIT;
            ST_RD_WAIT: if (rsp_valid) st_d = rsp_err ? ST_IDLE : ST_WR_REQ;
            ST_WR_REQ:  if (bus_ready) st_d = ST_WR_WAIT;
            ST_WR_WAIT: if (rsp_valid) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_RD_WAIT && rsp_valid && !rsp_err) begin
                data_q <= rsp_rdata & size_mask(src_size) & size_mask(dst_size);
            end
        end
    end

    assign bus_valid = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
    assign bus_write = (st_q == ST_WR_REQ);
    assign bus_addr  = bus_write ? dst_addr : src_addr;
    assign bus_size  = bus_write ? dst_size : src_size;
    assign bus_wdata = data_q;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              per_req,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_rdata,
    input  logic              bus_rsp_err,
    output logic              evt_done,
    output logic              evt_half,
    output logic              evt_err,
    output logic [15:0]       ctrl_out,
    output logic [CW-1:0]     remain_cnt,
    output logic [AW-1:0]     per_addr,
    output logic [AW-1:0]     mem_addr
);
    localparam int NSIDE = 2;  // 0: peripheral side, 1: memory side

    ctrl_t         ctrl;
    logic          err_hit;
    logic          beat_done;
    logic          cnt_nonzero;
    logic          wrap;
    logic          done_pulse;
    logic          half_pulse;
    logic          err_q;
    logic          start;
    logic [AW-1:0] ptr       [NSIDE];
    logic [1:0]    side_size [NSIDE];
    logic [NSIDE-1:0] side_inc;

    dma_ch_ctrl_reg #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_we && (cfg_sel == SEL_CTRL)),
        .wdata      (cfg_wdata),
        .hw_disable (err_hit),
        .ctrl       (ctrl)
    );

    dma_ch_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_we && (cfg_sel == SEL_COUNT)),
        .wdata      (cfg_wdata[CW-1:0]),
        .en         (ctrl.en),
        .circ       (ctrl.circ),
        .beat_done  (beat_done),
        .remain     (remain_cnt),
        .nonzero    (cnt_nonzero),
        .wrap       (wrap),
        .done_pulse (done_pulse),
        .half_pulse (half_pulse)
    );

    assign side_size[0] = ctrl.psize;
    assign side_size[1] = ctrl.msize;
    assign side_inc     = {ctrl.minc, ctrl.pinc};

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        localparam logic [1:0] SIDE_SEL = (g == 0) ? SEL_PADDR : SEL_MADDR;
        dma_ch_addr_ptr #(.AW(AW)) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .wr      (cfg_we && (cfg_sel == SIDE_SEL)),
            .wdata   (cfg_wdata),
            .step_en (beat_done && side_inc[g]),
            .size    (side_size[g]),
            .reload  (wrap),
            .cur     (ptr[g])
        );
    end

    assign start = ctrl.en && cnt_nonzero && (ctrl.m2m || per_req);

    dma_ch_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src_addr  (ctrl.dir ? ptr[1] : ptr[0]),
        .dst_addr  (ctrl.dir ? ptr[0] : ptr[1]),
        .src_size  (ctrl.dir ? side_size[1] : side_size[0]),
        .dst_size  (ctrl.dir ? side_size[0] : side_size[1]),
        .bus_ready (bus_ready),
        .rsp_valid (bus_rsp_valid),
        .rsp_rdata (bus_rsp_rdata),
        .rsp_err   (bus_rsp_err),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .beat_done (beat_done),
        .err_hit   (err_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_hit;
        end
    end

    assign evt_done = done_pulse && ctrl.done_ie;
    assign evt_half = half_pulse && ctrl.half_ie;
    assign evt_err  = err_q && ctrl.err_ie;
    assign ctrl_out = {1'b0, ctrl};
    assign per_addr = ptr[0];
    assign mem_addr = ptr[1];
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic          bus_ready,
    input logic          bus_rsp_valid,
    input logic          bus_rsp_err,
    input logic          evt_done,
    input logic          evt_err,
    input logic [15:0]   ctrl_out,
    input logic [CW-1:0] remain_cnt
);
    logic outstanding_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
        end else if (bus_valid && bus_ready) begin
            outstanding_q <= 1'b1;
        end else if (bus_rsp_valid) begin
            outstanding_q <= 1'b0;
        end
    end

    a_r13_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                    && $stable(bus_size) && $stable(bus_write));

    a_r13_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        outstanding_q |-> !bus_valid);

    a_r9_err_disables: assert property (@(posedge clk) disable iff (rst)
        outstanding_q && bus_rsp_valid && bus_rsp_err |=> !ctrl_out[0]);

    a_r9_err_event: assert property (@(posedge clk) disable iff (rst)
        outstanding_q && bus_rsp_valid && bus_rsp_err && ctrl_out[3] |=> evt_err);

    a_r10_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) && !bus_write |-> $past(ctrl_out[0]) && ($past(remain_cnt) != '0));

    a_r3_count_locked: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_out[0]) && (remain_cnt != $past(remain_cnt))
        |-> (remain_cnt == CW'($past(remain_cnt) - 1)) || ($past(remain_cnt) == CW'(1)));

    a_r6_done_zero: assert property (@(posedge clk) disable iff (rst)
        evt_done && !ctrl_out[5] |-> remain_cnt == '0);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_ready     (bus_ready),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_err   (bus_rsp_err),
    .evt_done      (evt_done),
    .evt_err       (evt_err),
    .ctrl_out      (ctrl_out),
    .remain_cnt    (remain_cnt)
);

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
    import dma_chan_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          per_req = 1'b0;
    logic          bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [31:0]   bus_wdata;
    logic          bus_ready = 1'b1;
    logic          bus_rsp_valid = 1'b0;
    logic [31:0]   bus_rsp_rdata = '0;
    logic          bus_rsp_err = 1'b0;
    logic          evt_done, evt_half, evt_err;
    logic [15:0]   ctrl_out;
    logic [CW-1:0] remain_cnt;
    logic [AW-1:0] per_addr, mem_addr;

    dma_chan_engine #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .per_req(per_req), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata), .bus_rsp_err(bus_rsp_err),
        .evt_done(evt_done), .evt_half(evt_half), .evt_err(evt_err), .ctrl_out(ctrl_out),
        .remain_cnt(remain_cnt), .per_addr(per_addr), .mem_addr(mem_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } item_t;

    item_t       exp_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    int          n_rd_acc = 0, n_wr_acc = 0, n_unexp = 0, n_stall = 0;
    int          n_done = 0, n_half = 0, n_err = 0;
    logic [CW-1:0] rem_at_half = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    bit          stall_mode = 1'b0;
    bit          finished = 1'b0;

    function automatic logic [31:0] rd_pattern(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    function automatic logic [31:0] msk(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_rd(input logic [31:0] a, input logic [1:0] s);
        exp_q.push_back('{wr: 1'b0, addr: a, size: s, data: 32'h0});
    endtask

    task automatic push_wr(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
        exp_q.push_back('{wr: 1'b1, addr: a, size: s, data: d});
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Bus responder and scoreboard monitor
    initial begin : responder
        bit          pend = 1'b0;
        bit          pend_err = 1'b0;
        logic [31:0] pend_data = '0;
        int          phase = 0;
        forever begin
            @(negedge clk);
            bus_rsp_valid = 1'b0;
            bus_rsp_err   = 1'b0;
            if (pend) begin
                bus_rsp_valid = 1'b1;
                bus_rsp_err   = pend_err;
                bus_rsp_rdata = pend_data;
                pend = 1'b0;
            end
            phase++;
            bus_ready = stall_mode ? phase[0] : 1'b1;
            if (!rst && bus_valid) begin
                if (!bus_ready) begin
                    n_stall++;
                end else begin
                    if (exp_q.size() == 0) begin
                        n_unexp++;
                        n_checks++; n_errors++;
                        $display("FAIL R4 unexpected command: actual addr %0h expected none", bus_addr);
                    end else begin
                        item_t e;
                        e = exp_q.pop_front();
                        check("R4 direction", {63'd0, bus_write}, {63'd0, e.wr});
                        check("R5 address", {32'd0, bus_addr}, {32'd0, e.addr});
                        check("R4 size", {62'd0, bus_size}, {62'd0, e.size});
                        if (e.wr) check("R12 data", {32'd0, bus_wdata}, {32'd0, e.data});
                    end
                    if (bus_write) n_wr_acc++; else n_rd_acc++;
                    pend      = 1'b1;
                    pend_err  = (bus_addr == err_addr);
                    pend_data = bus_write ? 32'h0 : rd_pattern(bus_addr);
                end
            end
            if (evt_done) n_done++;
            if (evt_half) begin n_half++; rem_at_half = remain_cnt; end
            if (evt_err)  n_err++;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin : main
        int base_wr, base_rd, base_done, base_half, base_err;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl", {48'd0, ctrl_out}, 64'd0);
        check("R1 count", {48'd0, remain_cnt}, 64'd0);
        check("R1 pointers", {per_addr, mem_addr}, 64'd0);
        check("R1 bus/events", {60'd0, bus_valid, evt_done, evt_half, evt_err}, 64'd0);

        // Memory-to-memory, word source, half destination, both incrementing
        cfg_write(2'd2, 32'h1000);
        cfg_write(2'd3, 32'h2000);
        cfg_write(2'd1, 32'd4);
        for (int i = 0; i < 4; i++) begin
            push_rd(32'h1000 + 4 * i, 2'd2);
            push_wr(32'h2000 + 2 * i, 2'd1, rd_pattern(32'h1000 + 4 * i) & msk(2'd1));
        end
        cfg_write(2'd0, 32'h46C7);
        check("R2 ctrl word", {48'd0, ctrl_out}, 64'h46C7);
        while (n_wr_acc < 4) @(negedge clk);
        idle(8);
        check("R6 count zero", {48'd0, remain_cnt}, 64'd0);
        check("R5 per pointer", {32'd0, per_addr}, 64'h1010);
        check("R5 mem pointer", {32'd0, mem_addr}, 64'h2008);
        check("R6 done once", n_done, 1);
        check("R8 half once", n_half, 1);
        check("R8 half point", {48'd0, rem_at_half}, 64'd2);
        check("R6 stays enabled", {63'd0, ctrl_out[0]}, 64'd1);
        check("R6 no extra items", exp_q.size() + n_unexp, 0);

        // Count write while enabled is ignored
        cfg_write(2'd1, 32'd9);
        idle(1);
        check("R3 locked count", {48'd0, remain_cnt}, 64'd0);
        cfg_write(2'd0, 32'h46C6);
        cfg_write(2'd1, 32'd3);
        idle(1);
        check("R3 count while disabled", {48'd0, remain_cnt}, 64'd3);

        // Circular, memory to peripheral, byte items, request driven
        cfg_write(2'd2, 32'h40);
        cfg_write(2'd3, 32'h300);
        base_rd = n_rd_acc; base_wr = n_wr_acc; base_done = n_done; base_half = n_half;
        cfg_write(2'd0, 32'h00B7);
        idle(10);
        check("R10 no request no item", n_rd_acc - base_rd, 0);
        check("R10 count held", {48'd0, remain_cnt}, 64'd3);
        for (int i = 0; i < 6; i++) begin
            push_rd(32'h300 + (i % 3), 2'd0);
            push_wr(32'h40, 2'd0, rd_pattern(32'h300 + (i % 3)) & 32'hFF);
            per_req = 1'b1;
            while (n_rd_acc < base_rd + i + 1) @(negedge clk);
            per_req = 1'b0;
            while (n_wr_acc < base_wr + i + 1) @(negedge clk);
            idle(4);
        end
        check("R7 count reloaded", {48'd0, remain_cnt}, 64'd3);
        check("R7 mem pointer reloaded", {32'd0, mem_addr}, 64'h300);
        check("R5 fixed per pointer", {32'd0, per_addr}, 64'h40);
        check("R7 done per pass", n_done - base_done, 2);
        check("R8 half per pass", n_half - base_half, 2);
        check("R10 item count", n_wr_acc - base_wr, 6);
        cfg_write(2'd0, 32'h00B6);

        // Error response with back-pressure, events partly masked
        stall_mode = 1'b1;
        err_addr = 32'h88;
        cfg_write(2'd2, 32'h80);
        cfg_write(2'd3, 32'h500);
        cfg_write(2'd1, 32'd4);
        push_rd(32'h80, 2'd2); push_wr(32'h500, 2'd2, rd_pattern(32'h80));
        push_rd(32'h84, 2'd2); push_wr(32'h504, 2'd2, rd_pattern(32'h84));
        push_rd(32'h88, 2'd2);
        base_half = n_half; base_err = n_err;
        cfg_write(2'd0, 32'h4AC9);
        while (n_err == base_err) @(negedge clk);
        idle(6);
        check("R9 enable cleared", {63'd0, ctrl_out[0]}, 64'd0);
        check("R9 count kept", {48'd0, remain_cnt}, 64'd2);
        check("R9 per pointer kept", {32'd0, per_addr}, 64'h88);
        check("R9 mem pointer kept", {32'd0, mem_addr}, 64'h508);
        check("R11 error event once", n_err - base_err, 1);
        check("R11 half masked", n_half - base_half, 0);
        check("R13 stalls seen", {63'd0, (n_stall > 0)}, 64'd1);
        check("R13 all items", exp_q.size() + n_unexp, 0);
        stall_mode = 1'b0;
        finish_sim();
    end
endmodule